// File: doc/BRIEF.md
# Recirculating Serial Shift Register

This block is a chain of clocked one-bit stages. Serial data enters at the head of the chain, and each rising clock edge moves every bit one place toward the tail. The tail stage drives the serial output, and the output of every stage is also brought out so that the whole word can be observed at once.

A mode line selects what feeds the head stage. In write mode the head stage takes the external serial input. In read mode the head stage takes the tail value instead, so the stored word rotates past the serial output and nothing is lost. A word of N bits can therefore be read out serially any number of times. After N read edges the register holds the same word it started with.

An active-low clear empties every stage. The clear is sampled on the clock edge and wins over both modes. The number of stages is a parameter with a default of four.

Top module: `recirc_shift_reg`

## Requirements
- R1: When `clear_n` is low at a rising edge, every bit of `taps` and `ser_out` is 0 after that edge. This holds whatever the values of `wr_en` and `ser_in`, so the clear takes priority over both modes.
- R2: At each rising edge with `clear_n` high, stage k+1 takes the value that stage k held before the edge (`taps[k+1]` takes the old `taps[k]`).
- R3: At each rising edge with `clear_n` high and `wr_en` = 1 (write mode), stage 0 (`taps[0]`) takes `ser_in`.
- R4: At each rising edge with `clear_n` high and `wr_en` = 0 (read mode), stage 0 takes the old value of the last stage.
- R5: A bit applied at `ser_in` in write mode appears at `ser_out` after exactly STAGES rising edges (4 by default), and not before. When a word w is written with its least significant bit first over STAGES edges, `taps[STAGES-1-i]` holds w[i], so w[0] is the first bit to reach `ser_out`.
- R6: In read mode the number of ones in the register never changes. After STAGES read edges, `taps` equals its value from before those edges.
- R7: `ser_out` always equals the registered value of the last stage (`taps[STAGES-1]`). It is stable between edges, so after k read edges from a freshly written word w it shows w[k mod STAGES].
- R8: In read mode `ser_in` has no effect. The rotated contents are the same whatever value `ser_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clear_n | input | 1 | Active-low clear, sampled on the clock edge |
| wr_en | input | 1 | Mode select: 1 = write (head stage takes `ser_in`), 0 = read (head stage takes the tail) |
| ser_in | input | 1 | External serial data, least significant bit first |
| ser_out | output | 1 | Serial output, driven by the last stage |
| taps | output | STAGES | Output of every stage; bit 0 is the head stage |

## Verification
Every stage result is due one edge after the inputs are presented: the head bit, each shifted bit and a clear all appear one edge later. A bit that is written shows up at `ser_out` only after STAGES edges, and a full rotation takes STAGES read edges. The bench drives its inputs shortly after an edge and samples one time unit after the next edge. It checks at each intermediate edge as well, so that a result which arrives one edge early or one edge late is caught.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

    localparam int RSR_STAGES_DEF = 4;

    typedef enum logic {
        MODE_READ  = 1'b0,
        MODE_WRITE = 1'b1
    } xfer_mode_e;

    // Picks the value the head stage takes on the next edge.
    function automatic logic head_feed(input xfer_mode_e mode,
                                       input logic       ext_bit,
                                       input logic       tail_bit);
        return (mode == MODE_WRITE) ? ext_bit : tail_bit;
    endfunction

endpackage

// File: rtl/rsr_feed_mux.sv
module rsr_feed_mux
    import rsr_pkg::*;
(
    input  xfer_mode_e mode,
    input  logic       ext_bit,
    input  logic       tail_bit,
    output logic       feed
);
    always_comb begin
        feed = head_feed(mode, ext_bit, tail_bit);
    end
endmodule

// File: rtl/rsr_stage.sv
module rsr_stage (
    input  logic clk,
    input  logic clear_n,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!clear_n) q <= 1'b0;
        else          q <= d;
    end
endmodule

// File: rtl/recirc_shift_reg.sv
module recirc_shift_reg
    import rsr_pkg::*;
#(
    parameter int STAGES = RSR_STAGES_DEF
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic              wr_en,
    input  logic              ser_in,
    output logic              ser_out,
    output logic [STAGES-1:0] taps
);
    localparam int LAST = STAGES - 1;

    xfer_mode_e  mode;
    logic        head_d;
    logic [STAGES-1:0] stage_d;

    assign mode = xfer_mode_e'(wr_en);

    rsr_feed_mux u_feed (
        .mode     (mode),
        .ext_bit  (ser_in),
        .tail_bit (taps[LAST]),
        .feed     (head_d)
    );

    assign stage_d[0] = head_d;

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_link
            assign stage_d[k] = taps[k-1];
        end
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            rsr_stage u_stage (
                .clk     (clk),
                .clear_n (clear_n),
                .d       (stage_d[k]),
                .q       (taps[k])
            );
        end
    endgenerate

    assign ser_out = taps[LAST];

    // Checks below start only after the first clear has been seen.
    logic seen_clear;
    always_ff @(posedge clk) begin
        if (!clear_n) seen_clear <= 1'b1;
        else if (seen_clear !== 1'b1) seen_clear <= 1'b0;
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk)
        !clear_n |=> (taps == '0)); // R1
    AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (!clear_n || !seen_clear)
        1'b1 |=> (taps[LAST:1] == $past(taps[LAST-1:0]))); // R2
    AST_WRITE_HEAD: assert property (@(posedge clk) disable iff (!clear_n || !seen_clear)
        wr_en |=> (taps[0] == $past(ser_in))); // R3
    AST_READ_HEAD: assert property (@(posedge clk) disable iff (!clear_n || !seen_clear)
        !wr_en |=> (taps[0] == $past(ser_out))); // R4
    AST_READ_KEEPS_ONES: assert property (@(posedge clk) disable iff (!clear_n || !seen_clear)
        !wr_en |=> ($countones(taps) == $past($countones(taps)))); // R6
endmodule

// File: tb/recirc_shift_reg_tb.sv
module recirc_shift_reg_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         clear_n;
    logic         wr_en;
    logic         ser_in;
    logic         ser_out;
    logic [N-1:0] taps;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    recirc_shift_reg #(.STAGES(N)) u_dut (
        .clk     (clk),
        .clear_n (clear_n),
        .wr_en   (wr_en),
        .ser_in  (ser_in),
        .ser_out (ser_out),
        .taps    (taps)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        clear_n = 1'b0; wr_en = 1'b1; ser_in = 1'b1;
        tick();
        clear_n = 1'b1;
    endtask

    // Expected taps after writing w LSB first: taps[N-1-i] = w[i]
    function automatic logic [N-1:0] placed(input logic [N-1:0] w);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[N-1-i] = w[i];
        return r;
    endfunction

    task automatic t_reset();
        do_clear();
        check("R1 taps after clear", taps, 0);
        check("R1 ser_out after clear", ser_out, 0);
    endtask

    task automatic write_word(input logic [N-1:0] w, input logic chk);
        wr_en = 1'b1;
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] prev;
            prev = taps;
            ser_in = w[i];
            tick();
            if (chk) begin
                check("R3 head takes ser_in", taps[0], w[i]);
                check("R2 chain shift", taps[N-1:1], prev[N-2:0]);
            end
        end
    endtask

    task automatic t_write(input logic [N-1:0] w);
        do_clear();
        write_word(w, 1'b1);
        check("R5 word placement", taps, placed(w));
        check("R7 ser_out is first bit", ser_out, w[0]);
    endtask

    task automatic t_latency();
        do_clear();
        wr_en = 1'b1;
        for (int e = 1; e <= N; e++) begin
            ser_in = (e == 1);
            tick();
            check("R5 latency", ser_out, (e == N));
        end
    endtask

    task automatic t_rotate(input logic [N-1:0] w, input logic junk);
        logic [N-1:0] start;
        do_clear();
        write_word(w, 1'b0);
        start = taps;
        wr_en = 1'b0;
        for (int k = 1; k <= N; k++) begin
            logic [N-1:0] prev;
            prev = taps;
            ser_in = junk ^ k[0];
            tick();
            check("R4 head takes tail", taps[0], prev[N-1]);
            check("R7 ser_out sequence", ser_out, w[k % N]);
        end
        check("R6 word restored", taps, start);
        check("R8 ser_in ignored in read", taps, placed(w));
    endtask

    task automatic t_clear_mid(input logic [N-1:0] w);
        do_clear();
        write_word(w, 1'b0);
        wr_en = 1'b0;
        tick();
        clear_n = 1'b0; wr_en = 1'b1; ser_in = 1'b1;
        tick();
        check("R1 clear beats write", taps, 0);
        clear_n = 1'b1; wr_en = 1'b0;
        tick();
        check("R1 stays empty in read", taps, 0);
    endtask

    bit done = 0;

    initial begin
        clear_n = 1'b0; wr_en = 1'b0; ser_in = 1'b0;
        #5;
        t_reset();
        t_write(4'b1011);
        t_write(4'b0110);
        t_latency();
        t_rotate(4'b1011, 1'b0);
        t_rotate(4'b0001, 1'b1);
        t_rotate(4'b1111, 1'b0);
        t_clear_mid(4'b1101);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule